// File: doc/BRIEF.md
# Programmable Interval Timer with Staged Reload

This block is an 8-bit bus peripheral that emits a one-clock pulse, meant to drive an interrupt line, once every N base ticks. N is a 24-bit interval. A single-cycle base tick input supplies the time unit, so the block only counts; it does not divide the system clock.

Software loads the interval one byte at a time into staging registers. These bytes do nothing on their own. The new value takes effect only after software writes the update bit in the control register. The update is applied at the next reload point of the counter. If the timer is idle because its active interval is zero, the update is applied at once. While a requested update waits, the control register reads back a pending flag. A separate enable bit gates the pulse output without stopping the count. An active interval of zero stops the timer completely.

Top module: `pit_timer`

## Requirements
- R1: Offsets 0, 1 and 2 hold the staged interval bytes: offset 0 is bits 7:0, offset 1 is bits 15:8 and offset 2 is bits 23:16. Each byte reads back the value last written to it.
- R2: Offset 3 is control/status. Bit 7 is the update/pending bit and bit 6 is the output enable. Bits 5:0 always read as zero, whatever was written to them.
- R3: Writing offset 3 with bit 7 set raises the pending flag, and bit 7 then reads 1 until the update is applied. Writing bit 7 as 0 requests nothing. Every write to offset 3 loads bit 6 into the enable.
- R4: With an active interval N of 1 or more, the counter steps once per base tick, and every Nth tick is an expiry. At an expiry, pulse_out is high for exactly the one clock that follows the edge on which the expiring tick was sampled.
- R5: When the enable is 0, no pulse is emitted, but counting continues. Setting the enable again lets the next expiry of the running count pulse.
- R6: An active interval of zero produces no pulses, whatever the enable holds.
- R7: A pending update loads the staged interval at the next expiry. That expiry still pulses, and the new interval times the following period. If the active interval is zero, the update loads on the next clock edge and the count starts over from the new value. The pending flag clears in the same cycle the load happens.
- R8: Writing a staging byte while an update is pending replaces the staged value, and the value present at apply time is the one loaded. Staging writes that are never committed do not change the period.
- R9: A read returns data on rd_data one clock after the edge that samples rd_en. rd_data is zero in any cycle that follows an edge with no read.
- R10: Reset clears the staged bytes, the active interval, the counter, the pending flag, the enable and both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | One-cycle base tick that advances the counter |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pulse_out | output | 1 | One-clock timer pulse |

## Verification
The hardest case to reach is an update that is requested while the timer runs. The new value must be held back until the running period expires, and the staged bytes may be rewritten during that wait. The stimulus counts ticks from a known start and commits a new interval partway through a period. It overwrites the staged byte before the expiry and reads the pending flag on both sides of that expiry. It then measures the spacing of the next pulse, which shows which value was loaded and when.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int PIT_DW = 8;
    localparam int PIT_NB = 3;

    typedef struct packed {
        logic pending;
        logic enable;
    } pit_ctrl_t;

    // a loaded count of one or zero ends the period on the next tick
    function automatic logic pit_at_end(input logic [PIT_DW*PIT_NB-1:0] cnt);
        return (cnt <= 1);
    endfunction

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int DW = PIT_DW,
    parameter int NB = PIT_NB,
    parameter int AW = $clog2(NB + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             apply_now,
    output logic [NB*DW-1:0] stg_val,
    output pit_ctrl_t        ctrl
);

    localparam int CTRL_OFF = NB;

    logic [NB-1:0][DW-1:0] stg_q;
    pit_ctrl_t             ctrl_q;

    for (genvar b = 0; b < NB; b++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q[b] <= '0;
            end else if (wr_en && addr == AW'(b)) begin
                stg_q[b] <= wr_data;
            end
        end
        assign stg_val[b*DW +: DW] = stg_q[b];
    end

    // a new request wins over the clear of the one being applied
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (apply_now) begin
                ctrl_q.pending <= 1'b0;
            end
            if (wr_en && addr == AW'(CTRL_OFF)) begin
                ctrl_q.enable <= wr_data[DW-2];
                if (wr_data[DW-1]) begin
                    ctrl_q.pending <= 1'b1;
                end
            end
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
#(
    parameter int IW = PIT_DW * PIT_NB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_in,
    input  logic [IW-1:0] stg_val,
    input  pit_ctrl_t     ctrl,
    output logic          apply_now,
    output logic [IW-1:0] act_val,
    output logic          pulse_out
);

    logic [IW-1:0] act_q;
    logic [IW-1:0] cnt_q;
    logic          pulse_q;
    logic          idle;
    logic          expire;

    always_comb begin
        idle      = (act_q == '0);
        expire    = tick_in && !idle && pit_at_end(cnt_q);
        apply_now = ctrl.pending && (idle || expire);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= expire && ctrl.enable;
            if (apply_now) begin
                act_q <= stg_val;
                cnt_q <= stg_val;
            end else if (expire) begin
                cnt_q <= act_q;
            end else if (tick_in && !idle) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign act_val   = act_q;
    assign pulse_out = pulse_q;

endmodule

// File: rtl/pit_rdmux.sv
module pit_rdmux
    import pit_pkg::*;
#(
    parameter int DW = PIT_DW,
    parameter int NB = PIT_NB,
    parameter int AW = $clog2(NB + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [NB*DW-1:0] stg_val,
    input  pit_ctrl_t        ctrl,
    output logic [DW-1:0]    rd_data
);

    logic [DW-1:0] sel;
    logic [DW-1:0] rd_q;

    always_comb begin
        sel = '0;
        for (int b = 0; b < NB; b++) begin
            if (addr == AW'(b)) begin
                sel = stg_val[b*DW +: DW];
            end
        end
        if (addr == AW'(NB)) begin
            sel = {ctrl.pending, ctrl.enable, {(DW-2){1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_en ? sel : '0;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int DW = PIT_DW,
    parameter int NB = PIT_NB,
    parameter int AW = $clog2(NB + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_in,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          pulse_out
);

    localparam int IW = DW * NB;

    logic [IW-1:0] stg_val;
    logic [IW-1:0] act_q;
    pit_ctrl_t     ctrl;
    logic          apply_now;
    logic          pending_q;
    logic          oe_q;

    pit_regs #(.DW(DW), .NB(NB), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .apply_now (apply_now),
        .stg_val   (stg_val),
        .ctrl      (ctrl)
    );

    pit_core #(.IW(IW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick_in   (tick_in),
        .stg_val   (stg_val),
        .ctrl      (ctrl),
        .apply_now (apply_now),
        .act_val   (act_q),
        .pulse_out (pulse_out)
    );

    pit_rdmux #(.DW(DW), .NB(NB), .AW(AW)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .addr    (addr),
        .stg_val (stg_val),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

    assign pending_q = ctrl.pending;
    assign oe_q      = ctrl.enable;

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int DW = 8,
    parameter int NB = 3,
    parameter int AW = 2,
    parameter int IW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_in,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] rd_data,
    input logic          pulse_out,
    input logic          pending_q,
    input logic          oe_q,
    input logic [IW-1:0] act_q
);

    p_ctrl_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == AW'(NB)) |=> (rd_data[DW-3:0] == '0));

    p_pending_set_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(NB) && wr_data[DW-1]) |=> pending_q);

    p_pulse_tick_r4: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> $past(tick_in));

    p_pulse_enable_r5: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> $past(oe_q));

    p_zero_silent_r6: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> ($past(act_q) != '0));

    p_load_needs_pending_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> $past(pending_q));

    p_idle_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0));

endmodule

bind pit_timer pit_timer_chk #(.DW(DW), .NB(NB), .AW(AW), .IW(DW*NB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_in   (tick_in),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .pulse_out (pulse_out),
    .pending_q (pending_q),
    .oe_q      (oe_q),
    .act_q     (act_q)
);

// File: tb/test_pit_timer.sv
`timescale 1ns/1ps
module test_pit_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_in = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pulse_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pit_timer i_pit_timer (
        .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .pulse_out(pulse_out)
    );

    typedef struct packed {
        logic [23:0] iv;
        logic        oe;
        logic [15:0] ticks;
        logic [15:0] expect_n;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{24'd3,      1'b1, 16'd12,  16'd4},
        '{24'd5,      1'b1, 16'd12,  16'd2},
        '{24'd1,      1'b1, 16'd6,   16'd6},
        '{24'd0,      1'b1, 16'd10,  16'd0},
        '{24'd4,      1'b0, 16'd12,  16'd0},
        '{24'h000103, 1'b1, 16'd300, 16'd1},
        '{24'h010000, 1'b1, 16'd20,  16'd0},
        '{24'd2,      1'b1, 16'd9,   16'd4}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_tick(output bit p);
        @(negedge clk);
        tick_in = 1'b1;
        @(posedge clk);
        #1 p = pulse_out;
        @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic program_iv(input logic [23:0] v);
        bus_write(2'd0, v[7:0]);
        bus_write(2'd1, v[15:8]);
        bus_write(2'd2, v[23:16]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit p;
        int cnt;

        // R10: reset state
        do_reset();
        for (int a = 0; a < 4; a++) begin
            bus_read(a[1:0], d);
            check("R10 reset register", {24'd0, d}, 32'd0);
        end
        check("R10 reset pulse", {31'd0, pulse_out}, 32'd0);

        // R9: rd_data returns to zero with no read
        @(negedge clk);
        @(posedge clk);
        #1 check("R9 idle read", {24'd0, rd_data}, 32'd0);

        // R1: staging byte positions and readback
        bus_write(2'd0, 8'hA5);
        bus_write(2'd1, 8'h5A);
        bus_write(2'd2, 8'h3C);
        bus_read(2'd0, d); check("R1 byte0", {24'd0, d}, 32'hA5);
        bus_read(2'd1, d); check("R1 byte1", {24'd0, d}, 32'h5A);
        bus_read(2'd2, d); check("R1 byte2", {24'd0, d}, 32'h3C);

        // R8: uncommitted staging has no effect
        bus_write(2'd3, 8'h40);
        cnt = 0;
        for (int i = 0; i < 5; i++) begin do_tick(p); cnt += p; end
        check("R8 uncommitted no pulses", cnt, 0);

        // R3 / R2: enable-only write requests nothing, low bits read zero
        bus_read(2'd3, d); check("R3 no request", {24'd0, d}, 32'h40);
        bus_write(2'd3, 8'h7F);
        bus_read(2'd3, d); check("R2 low bits zero", {24'd0, d}, 32'h40);

        // vector table
        for (int v = 0; v < 8; v++) begin
            do_reset();
            program_iv(VECS[v].iv);
            bus_write(2'd3, {1'b1, VECS[v].oe, 6'd0});
            cnt = 0;
            for (int t = 0; t < int'(VECS[v].ticks); t++) begin do_tick(p); cnt += p; end
            check($sformatf("R4/R5/R6 vector %0d pulse count", v), cnt, {16'd0, VECS[v].expect_n});
        end

        // R7: immediate apply when idle
        do_reset();
        program_iv(24'd4);
        bus_write(2'd3, 8'hC0);
        bus_read(2'd3, d); check("R7 immediate apply clears pending", {24'd0, d}, 32'h40);
        cnt = 0;
        for (int i = 0; i < 3; i++) begin do_tick(p); cnt += p; end
        check("R4 no early pulse", cnt, 0);
        do_tick(p); check("R4 pulse on 4th tick", {31'd0, p}, 32'd1);
        @(posedge clk); #1 check("R4 pulse one clock wide", {31'd0, pulse_out}, 32'd0);

        // R8 overwrite while pending; R3 pending visible; R7 deferred apply
        bus_write(2'd0, 8'd2);
        bus_write(2'd3, 8'hC0);
        bus_write(2'd0, 8'd3);
        bus_read(2'd3, d); check("R3 pending reads 1", {24'd0, d}, 32'hC0);
        cnt = 0;
        for (int i = 0; i < 3; i++) begin do_tick(p); cnt += p; end
        check("R7 old period no early pulse", cnt, 0);
        bus_read(2'd3, d); check("R7 still pending before expiry", {24'd0, d}, 32'hC0);
        do_tick(p); check("R7 expiry pulses with old interval", {31'd0, p}, 32'd1);
        bus_read(2'd3, d); check("R7 pending cleared at expiry", {24'd0, d}, 32'h40);
        cnt = 0;
        for (int i = 0; i < 2; i++) begin do_tick(p); cnt += p; end
        check("R8 overwritten value: no pulse in 2 ticks", cnt, 0);
        do_tick(p); check("R8 overwritten value: pulse on 3rd tick", {31'd0, p}, 32'd1);

        // R5: disable, counting continues
        bus_write(2'd3, 8'h00);
        cnt = 0;
        for (int i = 0; i < 5; i++) begin do_tick(p); cnt += p; end
        check("R5 disabled no pulses", cnt, 0);
        bus_write(2'd3, 8'h40);
        do_tick(p); check("R5 count kept running", {31'd0, p}, 32'd1);

        // R6: commit zero while running
        program_iv(24'd0);
        bus_write(2'd3, 8'hC0);
        cnt = 0;
        for (int i = 0; i < 2; i++) begin do_tick(p); cnt += p; end
        do_tick(p); cnt += p;
        check("R6 last pulse before stop", cnt, 1);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin do_tick(p); cnt += p; end
        check("R6 zero interval silent", cnt, 0);
        bus_read(2'd3, d); check("R6 pending cleared", {24'd0, d}, 32'h40);

        // R10: reset mid-run
        program_iv(24'd2);
        bus_write(2'd3, 8'hC0);
        do_reset();
        cnt = 0;
        for (int i = 0; i < 6; i++) begin do_tick(p); cnt += p; end
        check("R10 reset stops timer", cnt, 0);
        bus_read(2'd0, d); check("R10 staging cleared", {24'd0, d}, 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule